// File: doc/BRIEF.md
# Continuous code-density TDC calibrator

This block sits behind the fine-code decoder of a tapped-delay-line time-to-digital converter. Each detection event arrives as a strobe with a fine-bin index and the value of a free-running coarse counter. The block turns every event into a calibrated timestamp. Acquisition never stops. The same events that are stamped also fill a code-density histogram. Under uncorrelated arrival, the count in a bin is proportional to that bin's delay width.

When a window of `2^HIST_LOG2` hits has been collected, the histogram is frozen and cleared, and a walker builds a shadow table one bin per cycle. Each entry is the cumulative count up to the bin's centre, scaled to calibrated LSBs. When the walk ends, the shadow table becomes the active table in a single edge. Bins are never interpolated. Until the first table is built, a uniform-width table is used and the ready flag stays low.

Top module: `tdc_cal_top`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it is released, `out_valid_o` and `ready_o` are 0.
- R2: A strobe on `in_valid_i` in cycle c gives `out_valid_o` high in cycle c+2 and only then. This holds for a strobe in every cycle, and no event is dropped, including during a table rebuild.
- R3: The output timestamp is `(coarse * LSB_PER_COARSE - fine[bin]) mod 2^TS_W`. Here `fine` is the table that is active when the event is looked up, one cycle after it is sampled. Defaults: `LSB_PER_COARSE` = 133 and `TS_W` = 56.
- R4: Before the first table is complete, `fine[k] = floor((2k+1) * LSB_PER_COARSE / (2 * N_BINS))`, with `N_BINS` = 144.
- R5: The hit that completes a window is the `2^HIST_LOG2`-th valid hit since the previous window closed. If it is sampled at edge E, the new table is used for lookups from edge E+144 onward, and `ready_o` rises at that edge and then stays high.
- R6: A built table has `fine[k] = floor((2*S_k + c_k) * LSB_PER_COARSE / 2^(HIST_LOG2+1))`, where `c_k` is bin k's count in the window and `S_k` is the sum of the counts of bins 0 to k-1.
- R7: The histogram restarts from zero after each window. The hit sampled on the cycle after the completing hit, and every hit during the rebuild, counts toward the next window only.
- R8: Bins that received no hits in a window get the same calibrated fine time as one another when they are adjacent, so events in them give identical timestamps for the same coarse value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the coarse count period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Detection event strobe |
| in_bin_i | input | BIN_W (8) | Fine-bin index, 0 to N_BINS-1 |
| in_coarse_i | input | COARSE_W (48) | Coarse count captured with the event |
| out_valid_o | output | 1 | Calibrated timestamp valid |
| out_ts_o | output | TS_W (56) | Calibrated timestamp in LSBs |
| ready_o | output | 1 | A histogram-built table is active |

## Verification
Two pairs of events can fall in the same cycle. The first is the table swap and the lookup of a live event. The second is the freeze and clear of the histogram and the counting of a fresh hit. Both are provoked by streaming a hit on every cycle across the completing hit and the 144 cycles of rebuild that follow. An event sampled one edge before the swap must use the old table, and an event sampled at the swap edge must use the new one. The counts of the following window must exclude the hits of the window that just closed. This is judged by predicting every timestamp and the `ready_o` level from a bench-side histogram and table model.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  // centre of bin k for equal-width bins, in calibrated LSBs
  function automatic int unsigned uni_fine(int unsigned k, int unsigned n_bins,
                                           int unsigned lsb);
    return ((2 * k + 1) * lsb) / (2 * n_bins);
  endfunction
endpackage

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
  parameter int N_BINS    = 144,
  parameter int HIST_LOG2 = 16,
  parameter int BIN_W     = 8,
  parameter int CNT_W     = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic [BIN_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             done_o
);
  logic [HIST_LOG2-1:0] tot_q;
  logic                 hit_ok;
  logic [CNT_W-1:0]     snap_w [N_BINS];

  assign hit_ok = hit_i && (bin_i < BIN_W'(N_BINS));
  assign done_o = hit_ok && (tot_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tot_q <= '0;
    else if (hit_ok) tot_q <= tot_q + 1'b1;
  end

  for (genvar b = 0; b < N_BINS; b++) begin : g_bin
    logic [CNT_W-1:0] live_q, snap_q, nxt;
    logic             inc;
    assign inc = hit_ok && (bin_i == BIN_W'(b));
    assign nxt = (inc && live_q != '1) ? live_q + 1'b1 : live_q;  // saturate
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q <= '0;
        snap_q <= '0;
      end else if (done_o) begin
        snap_q <= nxt;
        live_q <= '0;
      end else begin
        live_q <= nxt;
      end
    end
    assign snap_w[b] = snap_q;
  end

  assign rd_cnt_o = (rd_idx_i < BIN_W'(N_BINS)) ? snap_w[rd_idx_i] : '0;
endmodule

// File: rtl/tdc_cal_build.sv
module tdc_cal_build #(
  parameter int N_BINS         = 144,
  parameter int HIST_LOG2      = 16,
  parameter int BIN_W          = 8,
  parameter int CNT_W          = 17,
  parameter int FINE_W         = 8,
  parameter int LSB_PER_COARSE = 133
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  output logic [BIN_W-1:0]  rd_idx_o,
  output logic              wr_en_o,
  output logic [BIN_W-1:0]  wr_idx_o,
  output logic [FINE_W-1:0] wr_val_o,
  output logic              swap_o,
  output logic              busy_o
);
  localparam int SUM_W  = HIST_LOG2 + 2;
  localparam int PROD_W = HIST_LOG2 + 1 + FINE_W;

  logic [BIN_W-1:0]  k_q;
  logic [CNT_W-1:0]  cum_q;
  logic              busy_q, last;
  logic [SUM_W-1:0]  half_sum;
  logic [PROD_W-1:0] prod;

  assign last     = (k_q == BIN_W'(N_BINS - 1));
  assign half_sum = {cum_q, 1'b0} + SUM_W'(rd_cnt_i);
  assign prod     = PROD_W'(half_sum) * PROD_W'(LSB_PER_COARSE);

  assign rd_idx_o = k_q;
  assign wr_idx_o = k_q;
  assign wr_en_o  = busy_q;
  assign wr_val_o = FINE_W'(prod >> (HIST_LOG2 + 1));
  assign swap_o   = busy_q && last;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      cum_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      k_q    <= '0;
      cum_q  <= '0;
    end else if (busy_q) begin
      cum_q <= cum_q + rd_cnt_i;
      k_q   <= k_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tdc_cal_stamp.sv
module tdc_cal_stamp
  import tdc_cal_pkg::*;
#(
  parameter int N_BINS         = 144,
  parameter int BIN_W          = 8,
  parameter int COARSE_W       = 48,
  parameter int TS_W           = 56,
  parameter int FINE_W         = 8,
  parameter int LSB_PER_COARSE = 133
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [BIN_W-1:0]    in_bin_i,
  input  logic [COARSE_W-1:0] in_coarse_i,
  input  logic                wr_en_i,
  input  logic [BIN_W-1:0]    wr_idx_i,
  input  logic [FINE_W-1:0]   wr_val_i,
  input  logic                swap_i,
  output logic                out_valid_o,
  output logic [TS_W-1:0]     out_ts_o,
  output logic                ready_o
);
  logic                sel_q, ready_q;
  logic [FINE_W-1:0]   act_w [N_BINS];
  logic                s1_v;
  logic [BIN_W-1:0]    s1_bin, rd_bin;
  logic [COARSE_W-1:0] s1_coarse;
  logic [FINE_W-1:0]   fine;

  for (genvar b = 0; b < N_BINS; b++) begin : g_ent
    localparam logic [FINE_W-1:0] UNI = FINE_W'(uni_fine(b, N_BINS, LSB_PER_COARSE));
    logic [FINE_W-1:0] e_q [2];
    for (genvar t = 0; t < 2; t++) begin : g_side
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) e_q[t] <= UNI;
        else if (wr_en_i && wr_idx_i == BIN_W'(b) && sel_q != 1'(t)) e_q[t] <= wr_val_i;
      end
    end
    assign act_w[b] = sel_q ? e_q[1] : e_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      ready_q <= 1'b0;
    end else if (swap_i) begin
      sel_q   <= ~sel_q;
      ready_q <= 1'b1;
    end
  end

  assign rd_bin = (s1_bin < BIN_W'(N_BINS)) ? s1_bin : BIN_W'(N_BINS - 1);
  assign fine   = act_w[rd_bin];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v        <= 1'b0;
      s1_bin      <= '0;
      s1_coarse   <= '0;
      out_valid_o <= 1'b0;
      out_ts_o    <= '0;
    end else begin
      s1_v        <= in_valid_i;
      if (in_valid_i) begin
        s1_bin    <= in_bin_i;
        s1_coarse <= in_coarse_i;
      end
      out_valid_o <= s1_v;
      if (s1_v)
        out_ts_o <= TS_W'(s1_coarse) * TS_W'(LSB_PER_COARSE) - TS_W'(fine);
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/tdc_cal_top.sv
module tdc_cal_top #(
  parameter int N_BINS         = 144,
  parameter int COARSE_W       = 48,
  parameter int HIST_LOG2      = 16,
  parameter int LSB_PER_COARSE = 133,
  localparam int BIN_W  = $clog2(N_BINS),
  localparam int CNT_W  = HIST_LOG2 + 1,
  localparam int FINE_W = $clog2(LSB_PER_COARSE + 1),
  localparam int TS_W   = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [BIN_W-1:0]    in_bin_i,
  input  logic [COARSE_W-1:0] in_coarse_i,
  output logic                out_valid_o,
  output logic [TS_W-1:0]     out_ts_o,
  output logic                ready_o
);
  logic              hist_done, swap, busy, wr_en;
  logic [BIN_W-1:0]  rd_idx, wr_idx;
  logic [CNT_W-1:0]  rd_cnt;
  logic [FINE_W-1:0] wr_val;

  tdc_cal_hist #(
    .N_BINS(N_BINS), .HIST_LOG2(HIST_LOG2), .BIN_W(BIN_W), .CNT_W(CNT_W)
  ) u_hist (
    .clk_i, .rst_ni, .hit_i(in_valid_i), .bin_i(in_bin_i),
    .rd_idx_i(rd_idx), .rd_cnt_o(rd_cnt), .done_o(hist_done)
  );

  tdc_cal_build #(
    .N_BINS(N_BINS), .HIST_LOG2(HIST_LOG2), .BIN_W(BIN_W), .CNT_W(CNT_W),
    .FINE_W(FINE_W), .LSB_PER_COARSE(LSB_PER_COARSE)
  ) u_build (
    .clk_i, .rst_ni, .start_i(hist_done), .rd_cnt_i(rd_cnt), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_val_o(wr_val), .swap_o(swap), .busy_o(busy)
  );

  tdc_cal_stamp #(
    .N_BINS(N_BINS), .BIN_W(BIN_W), .COARSE_W(COARSE_W), .TS_W(TS_W),
    .FINE_W(FINE_W), .LSB_PER_COARSE(LSB_PER_COARSE)
  ) u_stamp (
    .clk_i, .rst_ni, .in_valid_i, .in_bin_i, .in_coarse_i,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_val_i(wr_val), .swap_i(swap),
    .out_valid_o, .out_ts_o, .ready_o
  );
endmodule

// File: rtl/tdc_cal_chk.sv
module tdc_cal_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic out_valid_o,
  input logic ready_o,
  input logic hist_done,
  input logic swap,
  input logic busy
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 1'b1;
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  a_r5_swap_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> ready_o);

  a_r5_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r5_done_starts_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_done |=> busy);

  a_r7_no_window_during_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !hist_done);
endmodule

bind tdc_cal_top tdc_cal_chk u_chk (
  .clk_i, .rst_ni, .in_valid_i, .out_valid_o, .ready_o,
  .hist_done(hist_done), .swap(swap), .busy(busy)
);

// File: tb/tdc_cal_top_tb.sv
module tdc_cal_top_tb;
  localparam int CLK_P  = 10;
  localparam int NB     = 144;
  localparam int HL     = 10;
  localparam int NWIN   = 1 << HL;
  localparam int LSB    = 133;
  localparam int TSW    = 56;
  localparam int WALK   = 144;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_bin = '0;
  logic [47:0]       in_coarse = '0;
  logic              out_valid, ready;
  logic [TSW-1:0]    out_ts;

  int total = 0, bad = 0;
  bit finished = 0;

  tdc_cal_top #(.HIST_LOG2(HL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_bin_i(in_bin),
    .in_coarse_i(in_coarse), .out_valid_o(out_valid), .out_ts_o(out_ts), .ready_o(ready)
  );

  always #(CLK_P/2) clk = ~clk;

  // ---- bench-side model ----
  int hist_m [NB];
  int tbl_act [NB];
  int tbl_pend [NB];
  int tot_m = 0, cd = 0;
  bit exp_ready = 0, done_seen = 0;
  bit s1_v = 0, o_v = 0;
  logic [TSW-1:0] s1_ts, o_ts;

  function automatic logic [TSW-1:0] calc_ts(logic [47:0] c, int f);
    return TSW'(c) * TSW'(LSB) - TSW'(f);
  endfunction

  task automatic close_window();
    int cum = 0;
    for (int k = 0; k < NB; k++) begin
      tbl_pend[k] = ((2 * cum + hist_m[k]) * LSB) >> (HL + 1);
      cum += hist_m[k];
      hist_m[k] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          for (int k = 0; k < NB; k++) tbl_act[k] = tbl_pend[k];
          exp_ready = 1;
        end
      end
      o_v  = s1_v;
      o_ts = s1_ts;
      s1_v = in_valid;
      if (in_valid) begin
        s1_ts = calc_ts(in_coarse, tbl_act[in_bin]);
        hist_m[in_bin]++;
        tot_m++;
        if (tot_m == NWIN) begin
          tot_m = 0;
          close_window();
          cd = WALK;
          done_seen = 1;
        end
      end
    end
  end

  // continuous monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (out_valid !== o_v) begin
        bad++; $display("FAIL R2 out_valid act=%0b exp=%0b", out_valid, o_v);
      end
      if (o_v) begin
        total++;
        if (out_ts !== o_ts) begin
          bad++; $display("FAIL R3 R6 ts act=%0d exp=%0d", out_ts, o_ts);
        end
      end
      total++;
      if (ready !== exp_ready) begin
        bad++; $display("FAIL R5 ready act=%0b exp=%0b", ready, exp_ready);
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++; $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive one event, wait until its output is visible, return timestamp
  task automatic stamp_one(input logic [7:0] b, input logic [47:0] c,
                           output logic [TSW-1:0] ts);
    @(negedge clk);
    in_valid = 1; in_bin = b; in_coarse = c;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    ts = out_ts;
  endtask

  function automatic int uni(int k);
    return ((2 * k + 1) * LSB) / (2 * NB);
  endfunction

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction
  // widths 1,2,3 repeating -> total weight 288
  function automatic int pick(int r);
    int acc = 0;
    for (int k = 0; k < NB; k++) begin
      acc += 1 + (k % 3);
      if (r < acc) return k;
    end
    return NB - 1;
  endfunction

  // ---- scenarios ----
  task automatic t_reset();
    chk(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(ready === 1'b0, "R1 ready in reset", ready, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid after release", out_valid, 0);
    chk(ready === 1'b0, "R1 ready after release", ready, 0);
  endtask

  task automatic t_uniform();
    logic [TSW-1:0] ts;
    stamp_one(8'd0, 48'd1000, ts);
    chk(ts == calc_ts(48'd1000, uni(0)), "R4 bin0", ts, calc_ts(48'd1000, uni(0)));
    stamp_one(8'd143, 48'hFFFF_FFFF_FFFF, ts);
    chk(ts == calc_ts(48'hFFFF_FFFF_FFFF, uni(143)), "R4 bin143 max coarse", ts,
        calc_ts(48'hFFFF_FFFF_FFFF, uni(143)));
    stamp_one(8'd72, 48'd0, ts);
    chk(ts == calc_ts(48'd0, uni(72)), "R3 wrap at coarse 0", ts, calc_ts(48'd0, uni(72)));
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1; in_bin = 8'd10; in_coarse = 48'd55;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1'b0, "R2 no output at c+1", out_valid, 0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R2 output at c+2", out_valid, 1);
    chk(out_ts == calc_ts(48'd55, uni(10)), "R2 ts", out_ts, calc_ts(48'd55, uni(10)));
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 single output", out_valid, 0);
  endtask

  task automatic t_window1();
    logic [47:0] c = 48'h0000_0100_0000;
    logic [TSW-1:0] ts;
    int ks [4] = '{0, 1, 70, 143};
    forever begin
      @(negedge clk);
      if (done_seen) break;
      lfsr = step(lfsr);
      in_valid = 1; in_bin = 8'(pick(int'(lfsr) % 288)); in_coarse = c; c++;
    end
    // keep streaming across the rebuild and the swap edge (R7 concurrency)
    for (int i = 0; i < WALK + 6; i++) begin
      in_valid = 1; in_bin = 8'd0; in_coarse = c; c++;
      @(negedge clk);
    end
    in_valid = 0;
    chk(ready === 1'b1, "R5 ready after walk", ready, 1);
    foreach (ks[i]) begin
      stamp_one(8'(ks[i]), 48'd5000, ts);
      chk(ts == calc_ts(48'd5000, tbl_act[ks[i]]), "R6 built table", ts,
          calc_ts(48'd5000, tbl_act[ks[i]]));
    end
  endtask

  task automatic t_window2();
    logic [TSW-1:0] ta, tb;
    done_seen = 0;
    while (!done_seen) begin
      @(negedge clk);
      if (done_seen) break;
      in_valid = 1; in_bin = 8'd0; in_coarse = 48'd7;
    end
    in_valid = 0;
    repeat (WALK + 4) @(negedge clk);
    stamp_one(8'd100, 48'd9000, ta);
    stamp_one(8'd101, 48'd9000, tb);
    chk(ta == tb, "R8 empty adjacent bins equal", ta, tb);
    chk(ta == calc_ts(48'd9000, tbl_act[100]), "R7 second window", ta,
        calc_ts(48'd9000, tbl_act[100]));
    stamp_one(8'd0, 48'd9000, ta);
    chk(ta == calc_ts(48'd9000, tbl_act[0]), "R7 second window bin0", ta,
        calc_ts(48'd9000, tbl_act[0]));
  endtask

  initial begin
    for (int k = 0; k < NB; k++) begin
      hist_m[k] = 0; tbl_act[k] = uni(k); tbl_pend[k] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_uniform();
    t_latency();
    t_window1();
    t_window2();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule